// File: doc/BRIEF.md
# Completion queue head consumer

This block sits on the host side of a storage controller link and drains one circular completion queue held in host memory. A controller interrupt pulse or a software poll strobe wakes it. It then reads the upper half (dwords 2 and 3) of the entry at the current head. If the entry's phase bit shows that it is new, the block forwards the command identifier, submission queue identifier, submission queue head pointer and status on an output stream, then moves the head on.

It keeps reading until it meets an entry that is not new. At that point, if at least one entry was consumed, it issues a single 8-byte write of the final head index to the queue's head doorbell. This releases the slots back to the controller. Completions from different submission queues may arrive in any order, so every entry carries its own submission queue identifier downstream. The status is passed through unchanged, and a failed command releases its slot exactly like a successful one.

The control flow is one state machine with six states:
- IDLE waits for a trigger.
- FETCH presents the read request.
- AWAIT waits for the read data.
- JUDGE compares the phase bit.
- DELIVER offers the entry on the stream.
- RING writes the doorbell.

The transitions are:
- IDLE→FETCH on a trigger or a remembered trigger.
- FETCH→AWAIT on read accept.
- AWAIT→JUDGE on read data.
- JUDGE→DELIVER when the entry is new.
- JUDGE→RING when the entry is not new and the pass consumed something.
- JUDGE→IDLE when the entry is not new and the pass consumed nothing.
- DELIVER→FETCH on stream accept.
- RING→IDLE on doorbell accept.

Top module: `cq_head_consumer`

## Requirements
- R1: After reset the head index is 0, the expected phase is 1, and `rd_valid`, `cpl_valid` and `db_valid` are all low.
- R2: Each read request carries address `CQ_BASE + 16*head + 8` and fetches 8 bytes: dword 2 in `rd_rdata[31:0]` and dword 3 in `rd_rdata[63:32]`.
- R3: An entry is new only when its phase bit, `rd_rdata[48]` (dword 3 bit 16), equals the expected phase. Only new entries appear on the output stream.
- R4: For each new entry the stream carries `cpl_sqhd = rd_rdata[15:0]`, `cpl_sqid = rd_rdata[31:16]`, `cpl_cid = rd_rdata[47:32]` and `cpl_status = rd_rdata[63:49]`.
- R5: Each accepted stream beat advances the head by one. The head wraps from `DEPTH-1` to 0, and the expected phase inverts on each wrap.
- R6: All consecutive new entries are delivered before the doorbell is written. One doorbell write follows each pass that consumed at least one entry, and its data is the final head index.
- R7: The doorbell address is `BAR_BASE + 0x1000 + (2*QID+1)*(4<<DSTRD)`. The data is 64 bits wide with the head zero-extended.
- R8: A trigger that finds no new entry produces exactly one read, no stream beat and no doorbell write.
- R9: A trigger (`irq_pulse` or `poll_strobe`) that arrives while the block is busy is remembered, and it starts a further pass once the block is idle.
- R10: While `rd_valid`, `cpl_valid` or `db_valid` is high and its ready is low, the valid stays high and its payload stays stable.
- R11: An entry with a non-zero status is delivered and released exactly like one with zero status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pulse | input | 1 | Controller interrupt pulse |
| poll_strobe | input | 1 | Software poll strobe |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Byte address of entry dwords 2..3 |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 64 | Entry dwords 2 (low) and 3 (high) |
| cpl_valid | output | 1 | Completion stream valid |
| cpl_ready | input | 1 | Completion stream ready |
| cpl_status | output | 15 | Status field |
| cpl_sqid | output | 16 | Submission queue identifier |
| cpl_sqhd | output | 16 | Submission queue head pointer |
| cpl_cid | output | 16 | Command identifier |
| db_valid | output | 1 | Doorbell write valid |
| db_ready | input | 1 | Doorbell write accepted |
| db_addr | output | ADDR_W | Doorbell byte address |
| db_data | output | 64 | Doorbell data (head, zero-extended) |

## Verification
The bench builds the block with `DEPTH=8`, `QID=1` and `DSTRD=1`. The short ring means a few bursts of entries are enough to wrap the head more than once and flip the phase in both directions. The non-zero queue number and stride move the doorbell to offset 0x1018, which a wrong stride or index term would miss. Backpressure patterns on all three ready inputs and a held doorbell expose lost triggers and unstable payloads.

// File: rtl/cqc_pkg.sv
package cqc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_AWAIT,
        S_JUDGE,
        S_DELIVER,
        S_RING
    } cq_state_e;

    // Upper half of a completion entry as returned on the read port.
    localparam int HALF_W     = 64;
    localparam int PHASE_BIT  = 48;
    localparam int ENTRY_SHFT = 4;   // 16-byte entries
    localparam int HALF_OFS   = 8;   // dword 2 starts 8 bytes in

endpackage

// File: rtl/cqc_head.sv
module cqc_head #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] head,
    output logic             phase
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            phase <= 1'b1;
        end else if (advance) begin
            if (head == LAST) begin
                head  <= '0;
                phase <= ~phase;
            end else begin
                head  <= head + 1'b1;
            end
        end
    end

    AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        advance && head == LAST |=> head == '0 && phase != $past(phase)); // R5
    AST_STEP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance && head != LAST |=> $stable(phase)); // R5

endmodule

// File: rtl/cqc_addr.sv
module cqc_addr #(
    parameter int              ADDR_W   = 32,
    parameter int              IDX_W    = 4,
    parameter int              QID      = 1,
    parameter int              DSTRD    = 0,
    parameter logic [ADDR_W-1:0] CQ_BASE  = '0,
    parameter logic [ADDR_W-1:0] BAR_BASE = '0
) (
    input  logic [IDX_W-1:0]  head,
    output logic [ADDR_W-1:0] half_addr,
    output logic [ADDR_W-1:0] ring_addr
);
    import cqc_pkg::*;

    localparam logic [ADDR_W-1:0] RING_OFS =
        ADDR_W'(32'h1000 + (2 * QID + 1) * (4 << DSTRD));

    always_comb begin
        half_addr = CQ_BASE + (ADDR_W'(head) << ENTRY_SHFT) + ADDR_W'(HALF_OFS);
        ring_addr = BAR_BASE + RING_OFS;
    end

endmodule

// File: rtl/cq_head_consumer.sv
module cq_head_consumer #(
    parameter int                ADDR_W   = 32,
    parameter int                DEPTH    = 16,
    parameter int                QID      = 1,
    parameter int                DSTRD    = 0,
    parameter logic [ADDR_W-1:0] CQ_BASE  = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] BAR_BASE = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pulse,
    input  logic              poll_strobe,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rvalid,
    input  logic [63:0]       rd_rdata,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [14:0]       cpl_status,
    output logic [15:0]       cpl_sqid,
    output logic [15:0]       cpl_sqhd,
    output logic [15:0]       cpl_cid,
    output logic              db_valid,
    input  logic              db_ready,
    output logic [ADDR_W-1:0] db_addr,
    output logic [63:0]       db_data
);
    import cqc_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    cq_state_e          st_q, st_d;
    logic [IDX_W-1:0]   head;
    logic               exp_phase;
    logic               advance;
    logic               trig;
    logic [HALF_W-1:0]  ent_q;
    logic               drained_q;
    logic               pend_q;
    logic [ADDR_W-1:0]  half_addr, ring_addr;

    assign trig    = irq_pulse | poll_strobe;
    assign advance = (st_q == S_DELIVER) && cpl_ready;

    cqc_head #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .head    (head),
        .phase   (exp_phase)
    );

    cqc_addr #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .QID(QID), .DSTRD(DSTRD),
        .CQ_BASE(CQ_BASE), .BAR_BASE(BAR_BASE)
    ) u_addr (
        .head      (head),
        .half_addr (half_addr),
        .ring_addr (ring_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:    if (trig || pend_q) st_d = S_FETCH;
            S_FETCH:   if (rd_ready)       st_d = S_AWAIT;
            S_AWAIT:   if (rd_rvalid)      st_d = S_JUDGE;
            S_JUDGE: begin
                if (ent_q[PHASE_BIT] == exp_phase) st_d = S_DELIVER;
                else if (drained_q)                st_d = S_RING;
                else                               st_d = S_IDLE;
            end
            S_DELIVER: if (cpl_ready)      st_d = S_FETCH;
            S_RING:    if (db_ready)       st_d = S_IDLE;
            default:                       st_d = S_IDLE;
        endcase
    end

    // Entry capture, pass bookkeeping and remembered trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q     <= '0;
            drained_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            if (st_q == S_AWAIT && rd_rvalid) ent_q <= rd_rdata;
            if (advance)                      drained_q <= 1'b1;
            else if (st_q == S_RING && db_ready) drained_q <= 1'b0;
            if (st_q == S_IDLE)               pend_q <= 1'b0;
            else if (trig)                    pend_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        rd_valid   = (st_q == S_FETCH);
        rd_addr    = half_addr;
        cpl_valid  = (st_q == S_DELIVER);
        cpl_sqhd   = ent_q[15:0];
        cpl_sqid   = ent_q[31:16];
        cpl_cid    = ent_q[47:32];
        cpl_status = ent_q[63:49];
        db_valid   = (st_q == S_RING);
        db_addr    = ring_addr;
        db_data    = 64'(head);
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R10
    AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=> cpl_valid &&
        $stable({cpl_status, cpl_sqid, cpl_sqhd, cpl_cid})); // R10
    AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid && !db_ready |=> db_valid && $stable(db_data)); // R10
    AST_DELIVER_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> ent_q[PHASE_BIT] == exp_phase); // R3
    AST_RING_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(db_valid) |-> $past(st_q) == S_JUDGE && drained_q); // R6
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, cpl_valid, db_valid})); // R6

endmodule

// File: tb/sim_cq_head_consumer.sv
module sim_cq_head_consumer;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 8;
    localparam int          QID        = 1;
    localparam int          DSTRD      = 1;
    localparam logic [31:0] CQ_BASE    = 32'h1000_0000;
    localparam logic [31:0] BAR_BASE   = 32'hF000_0000;
    localparam logic [31:0] DB_EXP     = 32'hF000_1018;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        irq_pulse = 1'b0, poll_strobe = 1'b0;
    logic        rd_valid, rd_ready = 1'b0, rd_rvalid = 1'b0;
    logic [31:0] rd_addr;
    logic [63:0] rd_rdata = '0;
    logic        cpl_valid, cpl_ready = 1'b0;
    logic [14:0] cpl_status;
    logic [15:0] cpl_sqid, cpl_sqhd, cpl_cid;
    logic        db_valid, db_ready = 1'b0;
    logic [31:0] db_addr;
    logic [63:0] db_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    cq_head_consumer #(
        .ADDR_W(32), .DEPTH(DEPTH), .QID(QID), .DSTRD(DSTRD),
        .CQ_BASE(CQ_BASE), .BAR_BASE(BAR_BASE)
    ) u0 (.*);

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // Host memory and controller model
    logic [63:0] mem [DEPTH];
    int  ctl_tail = 0;
    bit  ctl_phase = 1;
    int  seq = 0;
    // Consumer reference model
    int  mhead = 0;
    bit  mphase = 1;
    int  db_head = 0, db_count = 0, emitted = 0, since_db = 0, reads = 0;
    bit  bp_mode = 0, hold_db = 0;
    int  cyc = 0, resp_cnt = 0, resp_idx = 0;
    bit  prev_rd_stall = 0, prev_cpl_stall = 0, prev_db_stall = 0;
    logic [31:0] prev_rd_addr;
    logic [62:0] prev_cpl;
    logic [63:0] prev_db;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic post(input int n);
        for (int i = 0; i < n; i++) begin
            logic [14:0] st;
            st = (seq % 3 == 0) ? 15'h0 : 15'(seq * 5 + 1);
            mem[ctl_tail] = {st, ctl_phase, 16'(16'h100 + seq * 7),
                             16'((seq * 3) % 5 + 1), 16'(seq)};
            seq++;
            ctl_tail = (ctl_tail + 1) % DEPTH;
            if (ctl_tail == 0) ctl_phase = ~ctl_phase;
        end
    endtask

    task automatic pulse(input bit use_irq);
        @(posedge clk); #2;
        if (use_irq) irq_pulse = 1'b1; else poll_strobe = 1'b1;
        @(posedge clk); #2;
        irq_pulse = 1'b0; poll_strobe = 1'b0;
    endtask

    task automatic settle();
        repeat (60) @(posedge clk);
        #2;
    endtask

    // Per-clock monitor: drives readies and read data, compares against the model
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            rd_ready <= 1'b0;
        end else begin
            rd_ready  = bp_mode ? cyc[0] : 1'b1;
            cpl_ready = bp_mode ? (cyc[1] ^ cyc[0]) : 1'b1;
            db_ready  = hold_db ? 1'b0 : (bp_mode ? (cyc[2] | cyc[0]) : 1'b1);
            // read data return
            rd_rvalid = 1'b0;
            if (resp_cnt > 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    rd_rvalid = 1'b1;
                    rd_rdata  = mem[resp_idx];
                end
            end
            // R10 stability
            if (prev_rd_stall)
                check(rd_valid && rd_addr == prev_rd_addr, "R10", "read hold",
                      64'(rd_addr), 64'(prev_rd_addr));
            if (prev_cpl_stall)
                check(cpl_valid && {cpl_status, cpl_sqid, cpl_sqhd, cpl_cid} == prev_cpl,
                      "R10", "stream hold", 64'({cpl_status, cpl_sqid, cpl_sqhd, cpl_cid}),
                      64'(prev_cpl));
            if (prev_db_stall)
                check(db_valid && db_data == prev_db, "R10", "doorbell hold", db_data, prev_db);
            prev_rd_stall  = rd_valid && !rd_ready;
            prev_rd_addr   = rd_addr;
            prev_cpl_stall = cpl_valid && !cpl_ready;
            prev_cpl       = {cpl_status, cpl_sqid, cpl_sqhd, cpl_cid};
            prev_db_stall  = db_valid && !db_ready;
            prev_db        = db_data;
            // R2 read request
            if (rd_valid && rd_ready) begin
                logic [31:0] ea;
                ea = CQ_BASE + 32'(mhead * 16 + 8);
                check(rd_addr == ea, "R2", "read address", 64'(rd_addr), 64'(ea));
                reads++;
                resp_cnt = 1 + (cyc % 3);
                resp_idx = mhead;
            end
            // R3/R4/R5/R11 stream beat
            if (cpl_valid && cpl_ready) begin
                logic [63:0] e;
                e = mem[mhead];
                check(e[48] == mphase, "R3", "delivered entry phase", 64'(e[48]), 64'(mphase));
                check(cpl_sqhd == e[15:0] && cpl_sqid == e[31:16] && cpl_cid == e[47:32],
                      "R4", "id fields", {16'h0, cpl_cid, cpl_sqid, cpl_sqhd},
                      {16'h0, e[47:0]});
                check(cpl_status == e[63:49], e[63:49] != 0 ? "R11" : "R4", "status",
                      64'(cpl_status), 64'(e[63:49]));
                emitted++; since_db++;
                mhead = (mhead + 1) % DEPTH;
                if (mhead == 0) mphase = ~mphase;
            end
            // R6/R7 doorbell
            if (db_valid && db_ready) begin
                check(db_addr == DB_EXP, "R7", "doorbell address", 64'(db_addr), 64'(DB_EXP));
                check(db_data == 64'(mhead), "R6", "doorbell head", db_data, 64'(mhead));
                check(since_db > 0, "R6", "doorbell after work", 64'(since_db), 64'd1);
                db_head = mhead; db_count++; since_db = 0;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int dbc, em, rc;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(!rd_valid && !cpl_valid && !db_valid, "R1", "idle after reset",
              64'({rd_valid, cpl_valid, db_valid}), 64'd0);

        // R1/R2/R6: single entry via interrupt, head starts at 0 with phase 1
        post(1); pulse(1); settle();
        check(db_head == ctl_tail, "R1", "first doorbell head", 64'(db_head), 64'(ctl_tail));

        // R6/R11: burst of five with failure status, one doorbell
        dbc = db_count; post(5); pulse(0); settle();
        check(db_count == dbc + 1, "R6", "one doorbell per pass", 64'(db_count), 64'(dbc + 1));
        check(db_head == ctl_tail, "R11", "all released", 64'(db_head), 64'(ctl_tail));

        // R8: nothing new
        dbc = db_count; em = emitted; rc = reads; pulse(1); settle();
        check(db_count == dbc && emitted == em, "R8", "no output on stale entry",
              64'(db_count + emitted), 64'(dbc + em));
        check(reads == rc + 1, "R8", "exactly one read", 64'(reads), 64'(rc + 1));

        // R5/R10: wrap twice under backpressure
        bp_mode = 1;
        post(5); pulse(1); settle(); settle();
        check(db_head == ctl_tail, "R5", "wrap head", 64'(db_head), 64'(ctl_tail));
        post(6); pulse(0); settle(); settle();
        check(db_head == ctl_tail, "R5", "second wrap head", 64'(db_head), 64'(ctl_tail));
        check(mphase == ctl_phase, "R5", "phase after wraps", 64'(mphase), 64'(ctl_phase));
        bp_mode = 0;

        // R9: trigger during doorbell hold is remembered
        hold_db = 1; dbc = db_count;
        post(2); pulse(1);
        wait (db_valid);
        post(1); pulse(0);
        @(posedge clk); #2 hold_db = 0;
        settle();
        check(db_count == dbc + 2, "R9", "second pass doorbell", 64'(db_count), 64'(dbc + 2));
        check(db_head == ctl_tail, "R9", "late entry released", 64'(db_head), 64'(ctl_tail));

        finish_run();
    end

endmodule